// File: doc/BRIEF.md
# Host-Bridge Outbound Address Translator

This block sits between a processor-side request port and the outbound request port of a PCI-style host bridge. Processor accesses that land in a fixed 1 GB window are forwarded to the bus. Accesses outside the window are refused without touching the bus. A control register chooses whether forwarded accesses become memory cycles or configuration cycles. It also supplies the two upper bus address bits used for memory cycles.

In configuration mode the window offset is split into a device number, a function number and a register byte offset. The device number becomes a single select bit in the bus address. Requests that would produce an out-of-range select are refused before any bus cycle starts. Configuration writes narrower than a dword are done as a read followed by a full-dword write with the new bytes merged in.

Only one request is handled at a time. A bus abort returns all ones to the processor and sets an abort flag, which stays set until software clears it with a write-one pulse.

Top module: `hbx_bridge`

## Requirements
- R1: An access is claimed only when cpu_addr[31:30] is 2'b10 (0x8000_0000 to 0xBFFF_FFFF). An unclaimed access issues no bus request and answers with status 3 (unclaimed) and read data 0.
- R2: A memory cycle drives bus_addr = {ctl_q[2:1], cpu_addr[29:0]}. cpu_size encodes the width (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). bus_be is the size mask shifted left by cpu_addr[1:0], with byte enables past lane 3 dropped. bus_wdata is cpu_wdata shifted up by 8 × cpu_addr[1:0].
- R3: Bus commands are encoded 0 = memory read, 1 = memory write, 2 = configuration read, 3 = configuration write. Forwarded accesses use configuration commands when ctl_q[0] is 1 and memory commands when it is 0. No other bus command exists.
- R4: In configuration mode the offset is decoded as device = cpu_addr[15:11], function = cpu_addr[10:8], register byte offset = cpu_addr[7:0]. The block drives bus_addr = (1 << (13 + device)) | (function << 8) | (offset with bits [1:0] cleared) and bus_be = 4'hF. Offset bits [29:16] are ignored.
- R5: A configuration access whose device number is above 18, or whose computed address is 0x10_0000 or more, issues no bus request. It answers with status 2 (rejected) and read data 0xFFFF_FFFF.
- R6: When the bus answers with bus_abort, the response carries status 1 (aborted). A read returns 0xFFFF_FFFF. If bus_done and bus_abort arrive together, the abort wins.
- R7: A bus abort sets abort_flag in the next cycle. The flag holds until a cycle with abort_clr high and no new abort. When an abort and a clear fall in the same cycle, the set wins.
- R8: A configuration write with a byte mask other than 4'hF issues a configuration read, then a configuration write of the same address with bus_be = 4'hF. The write data is the read dword with the written lanes replaced. An abort on the read ends the access with no write.
- R9: cpu_ready is low from the cycle after acceptance until the response cycle has passed. bus_req, bus_addr, bus_cmd and bus_wdata stay unchanged until bus_done or bus_abort.
- R10: Read data returned to the processor is the bus dword shifted down by 8 × cpu_addr[1:0] and masked to the access size, zero-extended. A completed write returns 0. Status 0 means success.
- R11: After reset, cpu_ready is 1, bus_req and resp_valid are 0, ctl_q is 0 and abort_flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Load the control register from ctl_wdata |
| ctl_wdata | input | 3 | Control value: bit 0 configuration select, bits 2:1 upper memory address bits |
| ctl_q | output | 3 | Current control register value |
| abort_clr | input | 1 | Write-one pulse that clears abort_flag |
| abort_flag | output | 1 | Sticky bus-abort indication |
| cpu_req | input | 1 | Processor request, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | Access width code |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_ready | output | 1 | Block idle and able to take a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 2 | 0 ok, 1 aborted, 2 rejected, 3 unclaimed |
| resp_rdata | output | 32 | Read data, right-aligned |
| bus_req | output | 1 | Outbound request active |
| bus_cmd | output | 2 | Outbound command code |
| bus_addr | output | 32 | Outbound bus address |
| bus_be | output | 4 | Outbound byte enables |
| bus_wdata | output | 32 | Outbound write data |
| bus_done | input | 1 | Bus completed the request |
| bus_abort | input | 1 | Bus aborted the request |
| bus_rdata | input | 32 | Bus read data, valid with bus_done |

## Verification
The assertions check on every cycle that a configuration request carries exactly one select bit, stays below the 1 MB limit and has a dword-aligned address. They also check that configuration writes always enable all four bytes and that an outstanding request holds its command, address and data steady. The abort flag's set and hold behaviour and the all-ones data of an aborted response are checked on every cycle as well. The scenarios show the things only specific stimulus reveals: the address arithmetic for chosen device, function and register values, the rejection boundary between device 6 and device 7, the byte merge of a read-modify-write, and lane extraction on narrow reads. They also cover the refusal of addresses outside the window, the memory upper-bit substitution, and clearing the abort flag.

// File: rtl/hbx_pkg.sv
// Shared types and helpers for the host-bridge outbound translator.
// Assumes a 32-bit data path with four byte lanes.
package hbx_pkg;
    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam int AW = 32;

    typedef enum logic [1:0] {
        CMD_MEM_RD = 2'd0,
        CMD_MEM_WR = 2'd1,
        CMD_CFG_RD = 2'd2,
        CMD_CFG_WR = 2'd3
    } hbx_cmd_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_ABORT     = 2'd1,
        ST_REJECT    = 2'd2,
        ST_UNCLAIMED = 2'd3
    } hbx_stat_e;

    // Expand a byte-enable vector into a bit mask.
    function automatic logic [DW-1:0] hbx_lane_bits(input logic [NB-1:0] be);
        logic [DW-1:0] r;
        r = '0;
        for (int i = 0; i < NB; i++) r[8*i +: 8] = {8{be[i]}};
        return r;
    endfunction
endpackage

// File: rtl/hbx_ctl_regs.sv
// Control register and sticky abort flag.
// Assumes abort_evt is a single-cycle pulse from the sequencer.
module hbx_ctl_regs #(
    parameter int CTL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             abort_evt,
    input  logic             abort_clr,
    output logic [CTL_W-1:0] ctl_q,
    output logic             abort_flag
);
    // Control register: loaded on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata;
    end

    // Sticky abort flag: a new abort beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         abort_flag <= 1'b0;
        else if (abort_evt) abort_flag <= 1'b1;
        else if (abort_clr) abort_flag <= 1'b0;
    end

    assert_abort_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> abort_flag);
    assert_abort_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag && !abort_clr |=> abort_flag);
    assert_abort_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_flag && !abort_evt |=> !abort_flag);
endmodule

// File: rtl/hbx_decode.sv
// Combinational request decoder: window claim, memory or configuration
// address formation, byte lanes and rejection of bad configuration targets.
// Assumes its inputs are only used in the cycle a request is accepted.
module hbx_decode
    import hbx_pkg::*;
#(
    parameter logic [1:0] WIN_TAG    = 2'b10,
    parameter int         DEV_LSB    = 11,
    parameter int         DEV_W      = 5,
    parameter int         FN_LSB     = 8,
    parameter int         FN_W       = 3,
    parameter int         SEL_BASE   = 13,
    parameter int         MAX_DEV    = 18,
    parameter int         CFG_SPAN_W = 20
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          cfg_sel,
    input  logic [1:0]    hi_bits,
    output logic          claim,
    output logic          reject,
    output logic          rmw,
    output hbx_cmd_e      cmd,
    output logic [AW-1:0] xaddr,
    output logic [NB-1:0] bus_be,
    output logic [NB-1:0] lane_be,
    output logic [1:0]    lane,
    output logic [DW-1:0] wdata_lane
);
    localparam int SEL_SPACE = 64;
    localparam int REG_W     = FN_LSB - 2;

    logic [NB-1:0]        size_mask;
    logic [2*NB-1:0]      lane_wide;
    logic [DEV_W-1:0]     dev;
    logic [FN_W-1:0]      fn;
    logic [REG_W-1:0]     reg_dw;
    logic [SEL_SPACE-1:0] sel_wide;
    logic                 beyond;
    logic [AW-1:0]        cfg_addr;

    // Byte mask for the access width.
    always_comb begin
        case (size)
            2'd0:    size_mask = 4'b0001;
            2'd1:    size_mask = 4'b0011;
            default: size_mask = 4'b1111;
        endcase
    end

    // Lane placement of mask and write data.
    always_comb begin
        lane       = addr[1:0];
        lane_wide  = {{NB{1'b0}}, size_mask} << lane;
        lane_be    = lane_wide[NB-1:0];
        wdata_lane = wdata << {lane, 3'b000};
    end

    // Configuration address: one-hot select, function and dword index.
    always_comb begin
        dev      = addr[DEV_LSB +: DEV_W];
        fn       = addr[FN_LSB +: FN_W];
        reg_dw   = addr[FN_LSB-1:2];
        sel_wide = SEL_SPACE'(1) << (SEL_BASE + int'(dev));
        beyond   = |sel_wide[SEL_SPACE-1:CFG_SPAN_W];
        cfg_addr = sel_wide[AW-1:0] | (AW'(fn) << FN_LSB) | (AW'(reg_dw) << 2);
    end

    // Claim, reject, command and final bus fields.
    always_comb begin
        claim  = (addr[AW-1:AW-2] == WIN_TAG);
        reject = claim && cfg_sel && ((int'(dev) > MAX_DEV) || beyond);
        rmw    = cfg_sel && we && (lane_be != {NB{1'b1}});
        if (cfg_sel) cmd = (we && !rmw) ? CMD_CFG_WR : CMD_CFG_RD;
        else         cmd = we ? CMD_MEM_WR : CMD_MEM_RD;
        xaddr  = cfg_sel ? cfg_addr : {hi_bits, addr[AW-3:0]};
        bus_be = cfg_sel ? {NB{1'b1}} : lane_be;
    end
endmodule

// File: rtl/hbx_seq.sv
// Single-outstanding request sequencer. Latches a decoded request, runs
// one bus cycle (two for a read-modify-write), formats the response.
// Assumes the bus raises bus_done or bus_abort for one cycle per request.
module hbx_seq
    import hbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          claim,
    input  logic          reject,
    input  logic          rmw,
    input  hbx_cmd_e      cmd,
    input  logic [AW-1:0] xaddr,
    input  logic [NB-1:0] dec_be,
    input  logic [NB-1:0] lane_be,
    input  logic [1:0]    lane,
    input  logic [DW-1:0] wdata_lane,
    input  logic          bus_done,
    input  logic          bus_abort,
    input  logic [DW-1:0] bus_rdata,
    output logic          cpu_ready,
    output logic          resp_valid,
    output hbx_stat_e     resp_status,
    output logic [DW-1:0] resp_rdata,
    output logic          bus_req,
    output hbx_cmd_e      bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [NB-1:0] bus_be,
    output logic [DW-1:0] bus_wdata,
    output logic          abort_evt
);
    typedef enum logic [1:0] {S_IDLE, S_BUS, S_GAP, S_RESP} seq_st_e;

    seq_st_e       state;
    logic [NB-1:0] lane_be_q;
    logic [1:0]    lane_q;
    logic          we_q;
    logic          rmw_q;
    logic [DW-1:0] lane_bits;
    logic [DW-1:0] merged;
    logic [DW-1:0] extracted;

    // Merge and extraction of byte lanes against the returned dword.
    always_comb begin
        lane_bits = hbx_lane_bits(lane_be_q);
        merged    = (bus_rdata & ~lane_bits) | (bus_wdata & lane_bits);
        extracted = (bus_rdata >> {lane_q, 3'b000}) & hbx_lane_bits(lane_be_q >> lane_q);
    end

    // Handshake strobes derived from the state.
    always_comb begin
        cpu_ready  = (state == S_IDLE);
        resp_valid = (state == S_RESP);
        bus_req    = (state == S_BUS);
        abort_evt  = (state == S_BUS) && bus_abort;
    end

    // Request state machine and latched request/response fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            bus_cmd     <= CMD_MEM_RD;
            bus_addr    <= '0;
            bus_be      <= '0;
            bus_wdata   <= '0;
            lane_be_q   <= '0;
            lane_q      <= '0;
            we_q        <= 1'b0;
            rmw_q       <= 1'b0;
            resp_status <= ST_OK;
            resp_rdata  <= '0;
        end else begin
            case (state)
                S_IDLE: if (cpu_req) begin
                    bus_cmd   <= cmd;
                    bus_addr  <= xaddr;
                    bus_be    <= dec_be;
                    bus_wdata <= wdata_lane;
                    lane_be_q <= lane_be;
                    lane_q    <= lane;
                    we_q      <= cpu_we;
                    rmw_q     <= rmw;
                    if (!claim) begin
                        resp_status <= ST_UNCLAIMED;
                        resp_rdata  <= '0;
                        state       <= S_RESP;
                    end else if (reject) begin
                        resp_status <= ST_REJECT;
                        resp_rdata  <= '1;
                        state       <= S_RESP;
                    end else begin
                        state <= S_BUS;
                    end
                end
                S_BUS: if (bus_abort) begin
                    resp_status <= ST_ABORT;
                    resp_rdata  <= we_q ? '0 : '1;
                    state       <= S_RESP;
                end else if (bus_done) begin
                    if (rmw_q) begin
                        bus_wdata <= merged;
                        bus_cmd   <= CMD_CFG_WR;
                        rmw_q     <= 1'b0;
                        state     <= S_GAP;
                    end else begin
                        resp_status <= ST_OK;
                        resp_rdata  <= we_q ? '0 : extracted;
                        state       <= S_RESP;
                    end
                end
                S_GAP:   state <= S_BUS;
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_cfg_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_cmd inside {CMD_CFG_RD, CMD_CFG_WR}) |->
            ($countones(bus_addr[AW-1:13]) == 1) && (bus_addr[1:0] == 2'b00));
    assert_cfg_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_cmd inside {CMD_CFG_RD, CMD_CFG_WR}) |-> (bus_addr[AW-1:20] == '0));
    assert_abort_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && (resp_status == ST_ABORT) && !we_q |-> (resp_rdata == '1));
    assert_cfg_write_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_cmd == CMD_CFG_WR) |-> (bus_be == {NB{1'b1}}));
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done && !bus_abort |=>
            bus_req && $stable(bus_addr) && $stable(bus_cmd) && $stable(bus_wdata));
endmodule

// File: rtl/hbx_bridge.sv
// Top of the outbound translator: control registers, request decoder and
// sequencer. Assumes a single clock domain and one request at a time.
module hbx_bridge
    import hbx_pkg::*;
#(
    parameter int CTL_W   = 3,
    parameter int MAX_DEV = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    input  logic             abort_clr,
    output logic             abort_flag,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [31:0]      cpu_addr,
    input  logic [1:0]       cpu_size,
    input  logic [31:0]      cpu_wdata,
    output logic             cpu_ready,
    output logic             resp_valid,
    output logic [1:0]       resp_status,
    output logic [31:0]      resp_rdata,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    output logic [31:0]      bus_addr,
    output logic [3:0]       bus_be,
    output logic [31:0]      bus_wdata,
    input  logic             bus_done,
    input  logic             bus_abort,
    input  logic [31:0]      bus_rdata
);
    logic          abort_evt;
    logic          claim, reject, rmw;
    hbx_cmd_e      dec_cmd;
    hbx_cmd_e      seq_cmd;
    hbx_stat_e     seq_stat;
    logic [AW-1:0] xaddr;
    logic [NB-1:0] dec_be, lane_be;
    logic [1:0]    lane;
    logic [DW-1:0] wdata_lane;

    hbx_ctl_regs #(.CTL_W(CTL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .abort_evt(abort_evt), .abort_clr(abort_clr),
        .ctl_q(ctl_q), .abort_flag(abort_flag)
    );

    hbx_decode #(.MAX_DEV(MAX_DEV)) u_dec (
        .addr(cpu_addr), .size(cpu_size), .we(cpu_we), .wdata(cpu_wdata),
        .cfg_sel(ctl_q[0]), .hi_bits(ctl_q[2:1]),
        .claim(claim), .reject(reject), .rmw(rmw), .cmd(dec_cmd),
        .xaddr(xaddr), .bus_be(dec_be), .lane_be(lane_be), .lane(lane),
        .wdata_lane(wdata_lane)
    );

    hbx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .claim(claim), .reject(reject), .rmw(rmw), .cmd(dec_cmd),
        .xaddr(xaddr), .dec_be(dec_be), .lane_be(lane_be), .lane(lane),
        .wdata_lane(wdata_lane), .bus_done(bus_done), .bus_abort(bus_abort),
        .bus_rdata(bus_rdata), .cpu_ready(cpu_ready), .resp_valid(resp_valid),
        .resp_status(seq_stat), .resp_rdata(resp_rdata), .bus_req(bus_req),
        .bus_cmd(seq_cmd), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .abort_evt(abort_evt)
    );

    // Enum outputs presented as plain vectors at the boundary.
    always_comb begin
        bus_cmd     = seq_cmd;
        resp_status = seq_stat;
    end
endmodule

// File: tb/hbx_bridge_tb.sv
module hbx_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic [2:0]  ctl_q;
    logic        abort_clr = 1'b0;
    logic        abort_flag;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [1:0]  cpu_size = '0;
    logic        cpu_ready, resp_valid;
    logic [1:0]  resp_status;
    logic [31:0] resp_rdata;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_done = 1'b0, bus_abort = 1'b0;
    logic [31:0] bus_rdata = '0;

    int errors = 0, checks = 0;
    bit finished = 0;

    // Bus responder settings and transaction log.
    int          rsp_lat = 1;
    bit          rsp_abort = 0;
    logic [31:0] rsp_rdata = '0;
    int          lg_n = 0;
    logic [1:0]  lg_cmd  [0:3];
    logic [31:0] lg_addr [0:3];
    logic [3:0]  lg_be   [0:3];
    logic [31:0] lg_wd   [0:3];

    logic [31:0] got_rdata;
    logic [1:0]  got_stat;
    int          busy_ready;

    hbx_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .abort_clr(abort_clr), .abort_flag(abort_flag),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .resp_valid(resp_valid), .resp_status(resp_status), .resp_rdata(resp_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_abort(bus_abort),
        .bus_rdata(bus_rdata)
    );

    always #2 clk = ~clk;

    // Bus model: answers each request after rsp_lat waiting cycles.
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            bus_done = 1'b0;
            bus_abort = 1'b0;
            if (bus_req) begin
                if (wcnt >= rsp_lat) begin
                    wcnt = 0;
                    if (lg_n < 4) begin
                        lg_cmd[lg_n] = bus_cmd; lg_addr[lg_n] = bus_addr;
                        lg_be[lg_n] = bus_be;   lg_wd[lg_n] = bus_wdata;
                    end
                    lg_n++;
                    bus_rdata = rsp_rdata;
                    if (rsp_abort) bus_abort = 1'b1;
                    else bus_done = 1'b1;
                end else wcnt++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [2:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic do_acc(input logic we, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd);
        @(negedge clk);
        lg_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        busy_ready = 0;
        for (int i = 0; i < 200; i++) begin
            if (resp_valid) break;
            if (cpu_ready) busy_ready++;
            @(negedge clk);
        end
        got_rdata = resp_rdata;
        got_stat  = resp_status;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R11 cpu_ready", 32'(cpu_ready), 32'd1);
        check("R11 bus_req", 32'(bus_req), 32'd0);
        check("R11 resp_valid", 32'(resp_valid), 32'd0);
        check("R11 ctl_q", 32'(ctl_q), 32'd0);
        check("R11 abort_flag", 32'(abort_flag), 32'd0);
    endtask

    task automatic t_mem;
        write_ctl(3'b010);
        do_acc(1'b1, 32'h8000_1236, 2'd1, 32'h0000_ABCD);
        check("R2 mem wr count", 32'(lg_n), 32'd1);
        check("R3 mem wr cmd", 32'(lg_cmd[0]), 32'd1);
        check("R2 mem wr addr", lg_addr[0], 32'h4000_1236);
        check("R2 mem wr be", 32'(lg_be[0]), 32'hC);
        check("R2 mem wr data", lg_wd[0], 32'hABCD_0000);
        check("R10 mem wr status", 32'(got_stat), 32'd0);
        write_ctl(3'b110);
        rsp_rdata = 32'h5A11_2233;
        do_acc(1'b0, 32'hBFFF_FFF3, 2'd0, 32'h0);
        check("R3 mem rd cmd", 32'(lg_cmd[0]), 32'd0);
        check("R2 mem rd addr", lg_addr[0], 32'hFFFF_FFF3);
        check("R2 mem rd be", 32'(lg_be[0]), 32'h8);
        check("R10 mem rd byte", got_rdata, 32'h0000_005A);
    endtask

    task automatic t_unclaimed;
        do_acc(1'b0, 32'h7FFF_FFFC, 2'd2, 32'h0);
        check("R1 low count", 32'(lg_n), 32'd0);
        check("R1 low status", 32'(got_stat), 32'd3);
        check("R1 low data", got_rdata, 32'd0);
        do_acc(1'b1, 32'hC000_0000, 2'd2, 32'h1234);
        check("R1 high count", 32'(lg_n), 32'd0);
        check("R1 high status", 32'(got_stat), 32'd3);
    endtask

    task automatic t_cfg_read;
        write_ctl(3'b001);
        rsp_rdata = 32'h1234_5678;
        do_acc(1'b0, 32'h8000_1110, 2'd2, 32'h0);
        check("R3 cfg rd cmd", 32'(lg_cmd[0]), 32'd2);
        check("R4 cfg rd addr", lg_addr[0], 32'h0000_8110);
        check("R4 cfg rd be", 32'(lg_be[0]), 32'hF);
        check("R10 cfg rd data", got_rdata, 32'h1234_5678);
        do_acc(1'b0, 32'h8000_1112, 2'd1, 32'h0);
        check("R10 cfg half read", got_rdata, 32'h0000_1234);
        do_acc(1'b0, 32'h8ABC_1110, 2'd2, 32'h0);
        check("R4 upper offset ignored", lg_addr[0], 32'h0000_8110);
    endtask

    task automatic t_reject;
        do_acc(1'b0, 32'h8000_3800, 2'd2, 32'h0);
        check("R5 dev7 count", 32'(lg_n), 32'd0);
        check("R5 dev7 status", 32'(got_stat), 32'd2);
        check("R5 dev7 data", got_rdata, 32'hFFFF_FFFF);
        do_acc(1'b0, 32'h8000_9800, 2'd2, 32'h0);
        check("R5 dev19 status", 32'(got_stat), 32'd2);
        do_acc(1'b0, 32'h8000_3000, 2'd2, 32'h0);
        check("R5 dev6 status", 32'(got_stat), 32'd0);
        check("R5 dev6 addr", lg_addr[0], 32'h0008_0000);
    endtask

    task automatic t_abort;
        rsp_abort = 1;
        do_acc(1'b0, 32'h8000_0004, 2'd2, 32'h0);
        check("R6 cfg abort status", 32'(got_stat), 32'd1);
        check("R6 cfg abort data", got_rdata, 32'hFFFF_FFFF);
        check("R4 cfg abort addr", lg_addr[0], 32'h0000_2004);
        check("R7 flag set", 32'(abort_flag), 32'd1);
        rsp_abort = 0;
        do_acc(1'b0, 32'h8000_0004, 2'd2, 32'h0);
        check("R7 flag sticky", 32'(abort_flag), 32'd1);
        @(negedge clk); abort_clr = 1'b1;
        @(negedge clk); abort_clr = 1'b0;
        check("R7 flag cleared", 32'(abort_flag), 32'd0);
        write_ctl(3'b000);
        rsp_abort = 1;
        do_acc(1'b0, 32'h8000_0010, 2'd0, 32'h0);
        check("R6 mem abort data", got_rdata, 32'hFFFF_FFFF);
        rsp_abort = 0;
        @(negedge clk); abort_clr = 1'b1;
        @(negedge clk); abort_clr = 1'b0;
    endtask

    task automatic t_rmw;
        write_ctl(3'b001);
        rsp_rdata = 32'hA1B2_C3D4;
        do_acc(1'b1, 32'h8000_0821, 2'd0, 32'h0000_00EE);
        check("R8 rmw count", 32'(lg_n), 32'd2);
        check("R8 rmw rd cmd", 32'(lg_cmd[0]), 32'd2);
        check("R8 rmw rd addr", lg_addr[0], 32'h0000_4020);
        check("R8 rmw wr cmd", 32'(lg_cmd[1]), 32'd3);
        check("R8 rmw wr addr", lg_addr[1], 32'h0000_4020);
        check("R8 rmw wr be", 32'(lg_be[1]), 32'hF);
        check("R8 rmw merged", lg_wd[1], 32'hA1B2_EED4);
        check("R8 rmw status", 32'(got_stat), 32'd0);
        do_acc(1'b1, 32'h8000_0820, 2'd2, 32'hCAFE_F00D);
        check("R8 full write count", 32'(lg_n), 32'd1);
        check("R8 full write cmd", 32'(lg_cmd[0]), 32'd3);
        check("R8 full write data", lg_wd[0], 32'hCAFE_F00D);
        rsp_abort = 1;
        do_acc(1'b1, 32'h8000_0822, 2'd1, 32'h0000_1111);
        check("R8 rmw abort count", 32'(lg_n), 32'd1);
        check("R8 rmw abort status", 32'(got_stat), 32'd1);
        rsp_abort = 0;
        @(negedge clk); abort_clr = 1'b1;
        @(negedge clk); abort_clr = 1'b0;
    endtask

    task automatic t_busy;
        rsp_lat = 4;
        do_acc(1'b0, 32'h8000_1110, 2'd2, 32'h0);
        check("R9 ready low while busy", 32'(busy_ready), 32'd0);
        check("R9 ready back", 32'(cpu_ready), 32'd1);
        rsp_lat = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mem();
        t_unclaimed();
        t_cfg_read();
        t_reject();
        t_abort();
        t_rmw();
        t_busy();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule